// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block takes a target programmable device through one complete configuration cycle. It owns the target's configuration pins from start to finish and pulls the active-low configuration-reset line low. It follows the target's reported mode through the reset phase and the configuration phase. It then forwards the image from a valid/ready word stream to the target's data bus.

When the stream ends, the controller waits for the target to confirm the load. It then sends a programmable number of trailing configuration clock pulses and waits for the target to report user mode. At that point it hands the pins back to the board.

A failed status check or a wait that runs too long stops the sequence in an error state with a cause code. A retry pulse restarts the sequence from the configuration-reset step. A reset of the controller part way through is a failed configuration, and the whole sequence must be started again.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset: `ncfg_o`=1, `pin_own_o`=0, `busy_o`=0, `done_o`=0, `error_o`=0, `in_ready_o`=0, `dclk_o`=0, `dclk_done_o`=0.
- R2: A `start_i` pulse in the idle or done state does the following.
  - It raises `busy_o` and `pin_own_o` and drives `ncfg_o` low.
  - `ncfg_o` stays low until the synchronized `mode_i` reads 1 (reset phase), then is released.
  - The controller then waits for `mode_i`=2 (configuration phase).
  - All status inputs pass through two-flop synchronizers.
- R3: A falling edge of the synchronized `nstatus_i` is held in a latch. The latch is cleared after the configuration phase is seen and before any word is accepted. As a result, the low `nstatus_i` of the reset phase does not fail the load.
- R4: `in_ready_o` and `data_en_o` are high only in the data phase.
  - Each accepted word appears on `cfg_data_o` with `cfg_wr_o`=1 one cycle after its handshake, in order.
  - The word accepted with `in_last_i`=1 ends the phase.
- R5: After the last word, the controller waits for `conf_done_i`=1 with `nstatus_i`=1 and then starts the trailing clocks.
  - `nstatus_i` low, or a latched fall, in the data or check phase gives error code 4.
  - No `conf_done_i` within the timeout gives code 5.
- R6: The trailing clock emits exactly `dclk_count_i` pulses on `dclk_o`. Each pulse is one cycle high followed by one cycle low.
- R7: `dclk_done_o` behaves as follows.
  - It sets on the second cycle after the last high cycle of `dclk_o`, and then holds.
  - A `dclk_done_clr_i` pulse clears it, except that a same-cycle set wins.
  - The controller clears it before each count and on entering the done state.
- R8: After the trailing clocks, the controller waits for `mode_i`=4 (user mode). It then enters done: `done_o`=1, `busy_o`=0, `pin_own_o`=0, `ncfg_o`=1.
- R9: Each wait is bounded by `timeout_i` cycles, with these error codes:
  - waiting for the reset phase: code 1;
  - waiting for the configuration phase: code 2;
  - waiting for user mode: code 3.
  - A `timeout_i` of 0 disables the bound.
- R10: In the error state:
  - `error_o`=1 with a nonzero `err_code_o`, and `busy_o`=0, `pin_own_o`=0;
  - `start_i` is ignored;
  - `retry_i` restarts at the configuration-reset step on the next cycle.
- R11: A reset during the data phase returns every output to the R1 state with `done_o`=0. A new `start_i` then runs a complete, successful sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration sequence |
| retry_i | input | 1 | Restart from the error state |
| dclk_count_i | input | CNT_W | Number of trailing clock pulses |
| timeout_i | input | TO_W | Wait bound in cycles, 0 = none |
| dclk_done_clr_i | input | 1 | Write-one clear of the pulse-done flag |
| mode_i | input | 3 | Target mode status |
| conf_done_i | input | 1 | Target load-complete status |
| nstatus_i | input | 1 | Target status, low on error or in reset |
| in_data_i | input | DW | Image word |
| in_valid_i | input | 1 | Image word valid |
| in_last_i | input | 1 | Final word of the image |
| in_ready_o | output | 1 | Image word accepted |
| cfg_data_o | output | DW | Data bus to the target |
| cfg_wr_o | output | 1 | Data bus strobe |
| ncfg_o | output | 1 | Configuration reset, active low |
| pin_own_o | output | 1 | Controller drives the configuration pins |
| data_en_o | output | 1 | Data forwarding enabled |
| dclk_o | output | 1 | Trailing configuration clock |
| dclk_done_o | output | 1 | Sticky all-pulses-sent flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Target reached user mode |
| error_o | output | 1 | Sequence failed |
| err_code_o | output | 3 | Failure cause |

## Verification
The assertions watch these rules on every cycle:
- the reset line is never low without pin ownership;
- data is accepted only while the pins are held and the reset line is released;
- each clock pulse is high for a single cycle;
- the done flag never sits beside a running count, and a clear without a set always takes effect;
- done and error release the pins, and a retry immediately pulls the reset line low again.

Only the scenarios show the rest:
- the latch clearing that hides the reset-phase status drop;
- the exact pulse count and the done-flag delay;
- each timeout and status cause code;
- recovery through retry and through a mid-transfer reset.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
package cfg_seq_pkg;
  localparam logic [2:0] MODE_PWRUP  = 3'd0;
  localparam logic [2:0] MODE_RESET  = 3'd1;
  localparam logic [2:0] MODE_CONFIG = 3'd2;
  localparam logic [2:0] MODE_INIT   = 3'd3;
  localparam logic [2:0] MODE_USER   = 3'd4;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_RST_TO   = 3'd1;
  localparam logic [2:0] ERR_CFG_TO   = 3'd2;
  localparam logic [2:0] ERR_USER_TO  = 3'd3;
  localparam logic [2:0] ERR_NSTATUS  = 3'd4;
  localparam logic [2:0] ERR_CDONE_TO = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LO, S_RST_REL, S_NS_CLR, S_DATA, S_CHK,
    S_DCLK_CLR, S_DCLK_RUN, S_USER, S_DONE, S_ERR
  } seq_state_e;
endpackage

// File: rtl/cfg_seq_sync.sv
`timescale 1ns/1ps
module cfg_seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_seq_timer.sv
`timescale 1ns/1ps
module cfg_seq_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  // limit 0 disables the bound
  assign expired_o = (limit_i != '0) && (cnt_q >= limit_i);

  // R9
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && cnt_q == '1) |=> (cnt_q == '1));
endmodule

// File: rtl/cfg_seq_dclk_gen.sv
`timescale 1ns/1ps
module cfg_seq_dclk_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic             dclk_o,
  output logic             done_o
);
  logic             run_q, dclk_q, done_q, fin_q;
  logic [CNT_W-1:0] rem_q;
  logic             start_ok;

  // a load is taken only with the flag already cleared
  assign start_ok = start_i & ~run_q & ~done_q & ~fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      dclk_q <= 1'b0;
      done_q <= 1'b0;
      fin_q  <= 1'b0;
      rem_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_ok) begin
        if (count_i == '0) fin_q <= 1'b1;
        else begin
          run_q  <= 1'b1;
          rem_q  <= count_i;
          dclk_q <= 1'b0;
        end
      end else if (run_q) begin
        if (!dclk_q) dclk_q <= 1'b1;
        else begin
          dclk_q <= 1'b0;
          rem_q  <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            run_q <= 1'b0;
            fin_q <= 1'b1;
          end
        end
      end
      // set wins over clear
      if (fin_q) done_q <= 1'b1;
      else if (clr_i) done_q <= 1'b0;
    end
  end

  assign dclk_o = dclk_q;
  assign done_o = done_q;

  // R6
  dclk_one_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_q |=> !dclk_q);
  // R6
  dclk_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_q |-> run_q);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q);
  // R7
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fin_q) |=> !done_q);
endmodule

// File: rtl/cfg_seq_ctrl.sv
`timescale 1ns/1ps
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CNT_W       = 16,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             retry_i,
  input  logic [CNT_W-1:0] dclk_count_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic             dclk_done_clr_i,
  input  logic [2:0]       mode_i,
  input  logic             conf_done_i,
  input  logic             nstatus_i,
  input  logic [DW-1:0]    in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic [DW-1:0]    cfg_data_o,
  output logic             cfg_wr_o,
  output logic             ncfg_o,
  output logic             pin_own_o,
  output logic             data_en_o,
  output logic             dclk_o,
  output logic             dclk_done_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic [2:0]       err_code_o
);
  localparam int SW = 5;

  seq_state_e    state_q, state_d;
  logic [2:0]    err_q, err_d;
  logic [SW-1:0] stat_s;
  logic [2:0]    mode_s;
  logic          cd_s, ns_s, ns_prev_q, ns_latch_q, ns_clr;
  logic          to_exp, gen_start, gen_clr, gen_done;
  logic          hs;
  logic [DW-1:0] data_q;
  logic          wr_q;

  cfg_seq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mode_i, conf_done_i, nstatus_i}),
    .q_o   (stat_s)
  );
  assign mode_s = stat_s[4:2];
  assign cd_s   = stat_s[1];
  assign ns_s   = stat_s[0];

  cfg_seq_timer #(.TO_W(TO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(state_d != state_q),
    .limit_i  (timeout_i),
    .expired_o(to_exp)
  );

  assign gen_start = (state_q == S_DCLK_RUN);
  assign gen_clr   = (state_q == S_DCLK_CLR) | dclk_done_clr_i |
                     ((state_q == S_USER) && (state_d == S_DONE));

  cfg_seq_dclk_gen #(.CNT_W(CNT_W)) u_dclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(gen_start),
    .count_i(dclk_count_i),
    .clr_i  (gen_clr),
    .dclk_o (dclk_o),
    .done_o (gen_done)
  );

  // nSTATUS fall latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_prev_q  <= 1'b0;
      ns_latch_q <= 1'b0;
    end else begin
      ns_prev_q <= ns_s;
      if (ns_clr) ns_latch_q <= 1'b0;
      else if (ns_prev_q && !ns_s) ns_latch_q <= 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    ns_clr  = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: if (start_i) begin
        state_d = S_RST_LO;
        err_d   = ERR_NONE;
      end
      S_RST_LO: begin
        if (mode_s == MODE_RESET) state_d = S_RST_REL;
        else if (to_exp) begin
          state_d = S_ERR;
          err_d   = ERR_RST_TO;
        end
      end
      S_RST_REL: begin
        if (mode_s == MODE_CONFIG) state_d = S_NS_CLR;
        else if (to_exp) begin
          state_d = S_ERR;
          err_d   = ERR_CFG_TO;
        end
      end
      S_NS_CLR: begin
        ns_clr  = 1'b1;
        state_d = S_DATA;
      end
      S_DATA: begin
        if (ns_latch_q || !ns_s) begin
          state_d = S_ERR;
          err_d   = ERR_NSTATUS;
        end else if (in_valid_i && in_last_i) state_d = S_CHK;
      end
      S_CHK: begin
        if (ns_latch_q || !ns_s) begin
          state_d = S_ERR;
          err_d   = ERR_NSTATUS;
        end else if (cd_s) state_d = S_DCLK_CLR;
        else if (to_exp) begin
          state_d = S_ERR;
          err_d   = ERR_CDONE_TO;
        end
      end
      S_DCLK_CLR: state_d = S_DCLK_RUN;
      S_DCLK_RUN: if (gen_done) state_d = S_USER;
      S_USER: begin
        if (mode_s == MODE_USER) state_d = S_DONE;
        else if (to_exp) begin
          state_d = S_ERR;
          err_d   = ERR_USER_TO;
        end
      end
      S_ERR: if (retry_i) begin
        state_d = S_RST_LO;
        err_d   = ERR_NONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // data stage: one register between handshake and target bus
  assign hs = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= hs;
      if (hs) data_q <= in_data_i;
    end
  end

  assign data_en_o   = (state_q == S_DATA);
  assign in_ready_o  = data_en_o & ns_s & ~ns_latch_q;
  assign cfg_data_o  = data_q;
  assign cfg_wr_o    = wr_q;
  assign ncfg_o      = (state_q != S_RST_LO);
  assign busy_o      = !(state_q inside {S_IDLE, S_DONE, S_ERR});
  assign pin_own_o   = busy_o;
  assign done_o      = (state_q == S_DONE);
  assign error_o     = (state_q == S_ERR);
  assign err_code_o  = err_q;
  assign dclk_done_o = gen_done;

  // R2
  ncfg_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ncfg_o |-> (pin_own_o && busy_o));
  // R4
  ready_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (pin_own_o && ncfg_o && data_en_o));
  // R6
  dclk_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> busy_o);
  // R8
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pin_own_o && ncfg_o && !error_o));
  // R10
  err_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!busy_o && err_code_o != ERR_NONE));
  // R10
  retry_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && retry_i) |=> (!ncfg_o && busy_o));
endmodule

// File: tb/cfg_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_tb_top;
  localparam int DW = 32, CNT_W = 16, TO_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic start_i = 0, retry_i = 0, dclk_done_clr_i = 0;
  logic [CNT_W-1:0] dclk_count_i = '0;
  logic [TO_W-1:0]  timeout_i = '0;
  logic [2:0] mode_i;
  logic conf_done_i, nstatus_i;
  logic [DW-1:0] in_data_i = '0;
  logic in_valid_i = 0, in_last_i = 0;
  logic in_ready_o, cfg_wr_o, ncfg_o, pin_own_o, data_en_o, dclk_o, dclk_done_o;
  logic busy_o, done_o, error_o;
  logic [DW-1:0] cfg_data_o;
  logic [2:0] err_code_o;

  cfg_seq_ctrl #(.DW(DW), .CNT_W(CNT_W), .TO_W(TO_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .retry_i(retry_i),
    .dclk_count_i(dclk_count_i), .timeout_i(timeout_i),
    .dclk_done_clr_i(dclk_done_clr_i), .mode_i(mode_i),
    .conf_done_i(conf_done_i), .nstatus_i(nstatus_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .cfg_data_o(cfg_data_o), .cfg_wr_o(cfg_wr_o),
    .ncfg_o(ncfg_o), .pin_own_o(pin_own_o), .data_en_o(data_en_o),
    .dclk_o(dclk_o), .dclk_done_o(dclk_done_o), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o), .err_code_o(err_code_o)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model controls
  bit t_stuck_pu = 0, t_stuck_rst = 0, t_bad_ns = 0, t_no_cd = 0, t_no_user = 0;
  int t_words = 0, t_pulses = 0, t_user_delay = 0;
  int wcnt = 0, pcnt = 0, uw = 0;
  logic dclk_prev_t = 0;

  initial begin
    mode_i = 3'd0; conf_done_i = 0; nstatus_i = 1;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (pin_own_o && !ncfg_o) begin
          if (!t_stuck_pu) mode_i = 3'd1;
          nstatus_i = 0; conf_done_i = 0; wcnt = 0; pcnt = 0;
        end else if (pin_own_o && mode_i == 3'd1 && !t_stuck_rst) begin
          mode_i = 3'd2; nstatus_i = 1;
        end
        if (cfg_wr_o) begin
          wcnt++;
          if (t_bad_ns) nstatus_i = 0;
          if (wcnt == t_words && !t_no_cd) conf_done_i = 1;
        end
        if (dclk_o && !dclk_prev_t) begin
          pcnt++;
          if (pcnt == t_pulses && conf_done_i) begin mode_i = 3'd3; uw = t_user_delay; end
        end else if (mode_i == 3'd3 && !t_no_user) begin
          if (uw == 0) mode_i = 3'd4; else uw--;
        end
        dclk_prev_t = dclk_o;
      end
    end
  end

  // scoreboard + pulse monitor
  logic [DW-1:0] exp_q[$];
  int p_seen = 0, last_hi = 0;
  logic prev_dd = 0, prev_dn = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (cfg_wr_o) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected write", cfg_data_o, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(cfg_data_o == e, "R4 word order", cfg_data_o, e);
        end
      end
      if (dclk_o) begin
        if (prev_dd) chk(0, "R6 pulse high >1 cycle", 2, 1);
        else p_seen++;
        last_hi = cyc;
      end
      if (dclk_done_o && !prev_dn && p_seen > 0)
        chk(cyc - last_hi == 2, "R7 flag timing", cyc - last_hi, 2);
    end
    prev_dd = dclk_o;
    prev_dn = dclk_done_o;
  end

  task automatic send_words(input int n, input int stop_after, input logic [DW-1:0] seed);
    for (int i = 0; i < stop_after; i++) begin
      in_data_i  = seed ^ (32'(i) * 32'h0001_0203);
      in_last_i  = (i == n - 1);
      in_valid_i = 1;
      while (!in_ready_o && !error_o && !done_o) @(negedge clk);
      if (!in_ready_o) break;
      exp_q.push_back(in_data_i);
      @(negedge clk);
    end
    in_valid_i = 0;
    in_last_i  = 0;
  endtask

  task automatic launch(input int words, input int pulses);
    t_words = words; t_pulses = pulses;
    dclk_count_i = CNT_W'(pulses);
    p_seen = 0;
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic wait_end(input int maxc);
    while (!done_o && !error_o && maxc > 0) begin @(negedge clk); maxc--; end
  endtask

  task automatic do_reset();
    rst_ni = 0;
    in_valid_i = 0; in_last_i = 0;
    t_stuck_pu = 0; t_stuck_rst = 0; t_bad_ns = 0; t_no_cd = 0; t_no_user = 0;
    t_user_delay = 0;
    mode_i = 3'd0; nstatus_i = 1; conf_done_i = 0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic chk_idle(input string req);
    chk(ncfg_o == 1 && pin_own_o == 0 && busy_o == 0, {req, " pins idle"},
        {ncfg_o, pin_own_o, busy_o}, 3'b100);
    chk(done_o == 0 && error_o == 0 && in_ready_o == 0, {req, " flags idle"},
        {done_o, error_o, in_ready_o}, 0);
    chk(dclk_o == 0 && dclk_done_o == 0, {req, " clock idle"}, {dclk_o, dclk_done_o}, 0);
  endtask

  task automatic chk_success(input string req, input int pulses);
    chk(done_o == 1 && error_o == 0, {req, " done"}, {done_o, error_o}, 2'b10);
    chk(pin_own_o == 0 && ncfg_o == 1 && busy_o == 0, "R8 pins released",
        {pin_own_o, ncfg_o, busy_o}, 3'b010);
    chk(p_seen == pulses, "R6 pulse count", p_seen, pulses);
    chk(dclk_done_o == 0, "R7 flag cleared after completion", dclk_done_o, 0);
    chk(exp_q.size() == 0, "R4 all words written", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk_idle("R1");
    rst_ni = 1;
    @(negedge clk);
    timeout_i = 16'd200;

    // R2 R3 R8: normal run, target drops nstatus in reset phase
    begin
      int lowc = 0;
      launch(8, 4);
      chk(busy_o && pin_own_o && !ncfg_o, "R2 start asserts reset", {busy_o, pin_own_o, ncfg_o}, 3'b110);
      while (!ncfg_o) begin lowc++; @(negedge clk); end
      chk(lowc >= 3, "R2 reset held until mode sync", lowc, 3);
      chk(busy_o == 1, "R2 busy while waiting config", busy_o, 1);
      send_words(8, 8, 32'hA5C3_0000);
      wait_end(500);
      chk_success("R3 R8 normal", 4);
    end

    // R6 single pulse
    launch(3, 1);
    send_words(3, 3, 32'h1111_0000);
    wait_end(500);
    chk_success("R6 one pulse", 1);

    // R6 large count 0x5000
    launch(2, 20480);
    send_words(2, 2, 32'h2222_0000);
    wait_end(50000);
    chk_success("R6 0x5000 pulses", 20480);

    // R7 external write-one clear while waiting for user mode
    t_user_delay = 40;
    launch(4, 4);
    send_words(4, 4, 32'h3333_0000);
    while (!dclk_done_o && !error_o) @(negedge clk);
    chk(dclk_done_o && busy_o, "R7 flag sticky", {dclk_done_o, busy_o}, 2'b11);
    @(negedge clk);
    chk(dclk_done_o == 1, "R7 flag holds", dclk_done_o, 1);
    dclk_done_clr_i = 1; @(negedge clk); dclk_done_clr_i = 0;
    chk(dclk_done_o == 0, "R7 write-one clear", dclk_done_o, 0);
    wait_end(500);
    chk_success("R7 run", 4);
    t_user_delay = 0;

    // R9 reset-phase timeout, then R10 error behaviour and retry
    timeout_i = 16'd40;
    t_stuck_pu = 1;
    launch(4, 4);
    wait_end(500);
    chk(error_o && err_code_o == 3'd1, "R9 reset-phase timeout code", err_code_o, 1);
    chk(!busy_o && !pin_own_o && ncfg_o, "R10 error releases pins", {busy_o, pin_own_o, ncfg_o}, 3'b001);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (4) @(negedge clk);
    chk(error_o && !busy_o && err_code_o == 3'd1, "R10 start ignored in error", {error_o, busy_o}, 2'b10);
    t_stuck_pu = 0;
    retry_i = 1; @(negedge clk); retry_i = 0;
    chk(busy_o && !ncfg_o, "R10 retry reasserts reset", {busy_o, ncfg_o}, 2'b10);
    p_seen = 0;
    send_words(4, 4, 32'h4444_0000);
    wait_end(500);
    chk_success("R10 retry run", 4);

    // R9 config-phase timeout
    t_stuck_rst = 1;
    launch(4, 4);
    wait_end(500);
    chk(error_o && err_code_o == 3'd2, "R9 config-phase timeout code", err_code_o, 2);
    do_reset();
    timeout_i = 16'd40;

    // R5 conf_done never rises
    t_no_cd = 1;
    launch(4, 4);
    send_words(4, 4, 32'h5555_0000);
    wait_end(500);
    chk(error_o && err_code_o == 3'd5, "R5 conf_done timeout code", err_code_o, 5);
    chk(p_seen == 0, "R5 no pulses without conf_done", p_seen, 0);
    do_reset();
    timeout_i = 16'd40;

    // R5 nstatus low during data
    t_bad_ns = 1;
    launch(6, 4);
    send_words(6, 6, 32'h6666_0000);
    wait_end(500);
    chk(error_o && err_code_o == 3'd4, "R5 nstatus failure code", err_code_o, 4);
    do_reset();
    timeout_i = 16'd40;

    // R9 user-mode timeout
    t_no_user = 1;
    launch(4, 4);
    send_words(4, 4, 32'h7777_0000);
    wait_end(500);
    chk(error_o && err_code_o == 3'd3, "R9 user-mode timeout code", err_code_o, 3);
    chk(p_seen == 4, "R9 pulses sent before user wait", p_seen, 4);
    do_reset();

    // R9 limit 0 disables bound
    timeout_i = '0;
    t_stuck_pu = 1;
    launch(4, 4);
    repeat (300) @(negedge clk);
    chk(busy_o && !error_o, "R9 zero limit never expires", {busy_o, error_o}, 2'b10);
    do_reset();
    timeout_i = 16'd200;

    // R11 reset mid-transfer
    launch(8, 4);
    send_words(8, 3, 32'h8888_0000);
    chk(data_en_o == 1, "R11 still in data phase", data_en_o, 1);
    rst_ni = 0;
    #1;
    chk_idle("R11");
    do_reset();
    timeout_i = 16'd200;
    launch(8, 4);
    send_words(8, 8, 32'h9999_0000);
    wait_end(500);
    chk_success("R11 rerun", 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule